// File: doc/BRIEF.md
# AFC Gearshift Loop Controller

This block is the digital loop filter of a receiver's automatic frequency correction. A bit-rate tick paces repeated correction cycles. Each cycle spends two bit times measuring, then one signed frequency-error sample is taken. The sample is divided by a power of two (the "gear") and added into a signed correction word, which steers a fractional-N synthesizer. After the correction is applied, the loop waits a programmable settling time before the next measurement starts.

Two sets of gear and timing settings are used. The acquisition set applies until a preamble is detected. The tracking set applies from detection until the end of the packet. A tracking timing code of zero stops the loop, so the correction is frozen for the rest of the packet. If the correction grows past a limit derived from the programmed deviation, it is dropped back to zero. The limit is twice the deviation, or the deviation itself when the halving bit is set. In multi-packet operation every packet end clears the correction, so that the next packet acquires its offset from scratch. A separate read-back word holds the result of the most recent correction step.

Top module: `afc_gearshift`

## Requirements
- R1: While `rst` is high, `corr_out` and `offset_rd` are zero from the next clock edge on, and the loop returns to the acquisition phase.
- R2: While the loop runs with timing code N (N nonzero), one cycle lasts 2+2·N bit ticks. The ticks in a cycle are numbered 1, 2, 3 and so on from the start of the cycle. The correction is applied only on tick number 2, and it is visible on `corr_out` after that clock edge.
- R3: A correction step adds `err_in` arithmetically shifted right by the active gear code (0 means full feedback, each step halves it) to the correction, and the sum is held to the signed `CORR_W`-bit range.
- R4: `ctrl_byte[5:3]` (gear) and `wait_pre` (timing) apply before preamble detection. `ctrl_byte[2:0]` and `wait_post` apply after it. The first `preamble_det` of a packet restarts the cycle at its measuring part.
- R5: A timing code of 0 stops the cycle counter. After preamble detection, `wait_post` = 0 therefore holds `corr_out` unchanged.
- R6: When the magnitude of a new correction value exceeds 2·`dev`, the correction becomes zero.
- R7: With `ctrl_byte[7]` set, the limit of R6 is 1·`dev`.
- R8: `pkt_end` restarts the cycle and returns the loop to the acquisition settings. It clears `corr_out` only when `multi_pkt` is high.
- R9: With `ctrl_byte[6]` (enable) low, `corr_out` is zero and the cycle counter is idle. When enable returns, a full cycle restarts.
- R10: A correction step whose sum leaves the `CORR_W`-bit signed range saturates at the range end.
- R11: `offset_rd` holds the result of the latest correction step, including a range reset to zero. It is not changed by a packet-end clear or by disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock pulse per received bit time |
| err_in | input | ERR_W | Signed frequency-error sample |
| preamble_det | input | 1 | Preamble detected pulse or level |
| pkt_end | input | 1 | End-of-packet pulse |
| multi_pkt | input | 1 | Multi-packet mode: clear correction at packet end |
| ctrl_byte | input | 8 | [7] limit halving, [6] enable, [5:3] acquisition gear, [2:0] tracking gear |
| wait_pre | input | 3 | Acquisition timing code |
| wait_post | input | 3 | Tracking timing code |
| dev | input | DEV_W | Programmed frequency deviation |
| corr_out | output | CORR_W | Signed correction word to the synthesizer |
| offset_rd | output | CORR_W | Read-back of the latest correction step result |

## Verification
Three cases need deliberate stimulus: saturation, the range reset, and the difference between `offset_rd` and `corr_out`. The bench reaches saturation by setting the deviation to its maximum, so the limit lies beyond the word range, and then feeding large same-sign errors. It reaches the range reset by lowering the deviation and accumulating steps until the limit is crossed, first with the halving bit clear and then with it set. It separates the read-back from the output by ending a packet in multi-packet mode right after a step, so `corr_out` is cleared while `offset_rd` must keep its value. Tick spacing and timing codes are varied so that the apply instant moves within the clock stream.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int CODE_W = 3;

    typedef struct packed {
        logic              halve;
        logic              enable;
        logic [CODE_W-1:0] gear_acq;
        logic [CODE_W-1:0] gear_trk;
    } afc_ctrl_t;

    typedef enum logic {
        PH_ACQ = 1'b0,
        PH_TRK = 1'b1
    } afc_phase_t;

    typedef struct packed {
        logic [CODE_W-1:0] gear;
        logic [CODE_W-1:0] timing;
    } afc_set_t;

    function automatic afc_set_t pick_set(afc_phase_t ph, afc_ctrl_t c,
                                          logic [CODE_W-1:0] t_acq,
                                          logic [CODE_W-1:0] t_trk);
        afc_set_t s;
        if (ph == PH_TRK) begin
            s.gear   = c.gear_trk;
            s.timing = t_trk;
        end else begin
            s.gear   = c.gear_acq;
            s.timing = t_acq;
        end
        return s;
    endfunction

endpackage

// File: rtl/afc_pacer.sv
module afc_pacer #(
    parameter int CODE_W = 3,
    localparam int CNT_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              apply
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;

    // cycle of 2 + 2N ticks: index runs 0 .. 2N+1
    assign last_idx = {code, 1'b1};
    assign apply    = run && !restart && tick && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == last_idx) ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/afc_accum.sv
module afc_accum #(
    parameter int ERR_W  = 10,
    parameter int CORR_W = 10,
    parameter int DEV_W  = 9,
    parameter int SH_W   = 3,
    localparam int SUM_W = ((ERR_W > CORR_W) ? ERR_W : CORR_W) + 1,
    localparam int LIM_W = DEV_W + 1,
    localparam int CMP_W = ((CORR_W > LIM_W) ? CORR_W : LIM_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     apply,
    input  logic                     clear,
    input  logic                     halve,
    input  logic [SH_W-1:0]          gear,
    input  logic signed [ERR_W-1:0]  err,
    input  logic [DEV_W-1:0]         dev,
    output logic signed [CORR_W-1:0] corr,
    output logic signed [CORR_W-1:0] last
);
    localparam logic signed [SUM_W-1:0] MAXV =
        SUM_W'({(CORR_W-1){1'b1}});
    localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

    logic signed [ERR_W-1:0]  scaled;
    logic signed [SUM_W-1:0]  sum;
    logic signed [CORR_W-1:0] sat;
    logic [CORR_W-1:0]        mag;
    logic [LIM_W-1:0]         limit;
    logic signed [CORR_W-1:0] nxt;

    always_comb begin
        scaled = err >>> gear;
        sum    = SUM_W'(corr) + SUM_W'(scaled);
        if (sum > MAXV)      sat = CORR_W'(MAXV);
        else if (sum < MINV) sat = CORR_W'(MINV);
        else                 sat = CORR_W'(sum);
        mag   = sat[CORR_W-1] ? CORR_W'(-sat) : CORR_W'(sat);
        limit = halve ? LIM_W'(dev) : {dev, 1'b0};
        nxt   = (CMP_W'(mag) > CMP_W'(limit)) ? '0 : sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr <= '0;
            last <= '0;
        end else if (!en || clear) begin
            corr <= '0;
        end else if (apply) begin
            corr <= nxt;
            last <= nxt;
        end
    end
endmodule

// File: rtl/afc_gearshift.sv
module afc_gearshift
    import afc_pkg::*;
#(
    parameter int ERR_W  = 10,
    parameter int CORR_W = 10,
    parameter int DEV_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_tick,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic                     preamble_det,
    input  logic                     pkt_end,
    input  logic                     multi_pkt,
    input  logic [7:0]               ctrl_byte,
    input  logic [CODE_W-1:0]        wait_pre,
    input  logic [CODE_W-1:0]        wait_post,
    input  logic [DEV_W-1:0]         dev,
    output logic signed [CORR_W-1:0] corr_out,
    output logic signed [CORR_W-1:0] offset_rd
);
    afc_ctrl_t  ctrl;
    afc_phase_t phase;
    afc_set_t   act;
    logic       seen;
    logic       restart;
    logic       run;
    logic       apply_evt;

    assign ctrl    = afc_ctrl_t'(ctrl_byte);
    assign act     = pick_set(phase, ctrl, wait_pre, wait_post);
    assign seen    = (phase == PH_TRK);
    assign restart = pkt_end || (preamble_det && !seen);
    assign run     = ctrl.enable && (act.timing != '0);

    always_ff @(posedge clk) begin
        if (rst || pkt_end)     phase <= PH_ACQ;
        else if (preamble_det)  phase <= PH_TRK;
    end

    afc_pacer #(.CODE_W(CODE_W)) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .tick    (bit_tick),
        .code    (act.timing),
        .apply   (apply_evt)
    );

    afc_accum #(
        .ERR_W  (ERR_W),
        .CORR_W (CORR_W),
        .DEV_W  (DEV_W),
        .SH_W   (CODE_W)
    ) u_accum (
        .clk   (clk),
        .rst   (rst),
        .en    (ctrl.enable),
        .apply (apply_evt),
        .clear (pkt_end && multi_pkt),
        .halve (ctrl.halve),
        .gear  (act.gear),
        .err   (err_in),
        .dev   (dev),
        .corr  (corr_out),
        .last  (offset_rd)
    );
endmodule

// File: rtl/afc_gearshift_chk.sv
module afc_gearshift_chk #(
    parameter int CORR_W = 10,
    parameter int DEV_W  = 9
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     pkt_end,
    input logic                     preamble_det,
    input logic [7:0]               ctrl_byte,
    input logic [2:0]               wait_post,
    input logic [DEV_W-1:0]         dev,
    input logic signed [CORR_W-1:0] corr_out,
    input logic signed [CORR_W-1:0] offset_rd,
    input logic                     seen,
    input logic                     apply_evt
);
    function automatic int unsigned mag_of(logic signed [CORR_W-1:0] v);
        return (v < 0) ? int'(-v) : int'(v);
    endfunction

    int unsigned lim_now;
    assign lim_now = ctrl_byte[7] ? int'(dev) : 2 * int'(dev);

    // R1: reset clears both words
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (corr_out == '0 && offset_rd == '0));

    // R9: disabled loop drives zero
    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        !ctrl_byte[6] |=> corr_out == '0);

    // R2: correction moves only on an apply instant or a clear
    a_r2_only_on_apply: assert property (@(posedge clk) disable iff (rst)
        (ctrl_byte[6] && !apply_evt && !pkt_end) |=> $stable(corr_out));

    // R5: tracking with timing code 0 freezes the output
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        (seen && wait_post == 3'd0 && ctrl_byte[6] && !pkt_end) |=> $stable(corr_out));

    // R6 / R7: after a step the magnitude stays inside the limit
    a_r6_within_limit: assert property (@(posedge clk) disable iff (rst)
        (apply_evt && ctrl_byte[6]) |=> mag_of(corr_out) <= $past(lim_now));

    // R11: read-back tracks the step result
    a_r11_readback: assert property (@(posedge clk) disable iff (rst)
        (apply_evt && ctrl_byte[6] && !pkt_end) |=> offset_rd == corr_out);

    // R11: read-back untouched without a step
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !apply_evt |=> $stable(offset_rd));
endmodule

bind afc_gearshift afc_gearshift_chk #(.CORR_W(CORR_W), .DEV_W(DEV_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pkt_end      (pkt_end),
    .preamble_det (preamble_det),
    .ctrl_byte    (ctrl_byte),
    .wait_post    (wait_post),
    .dev          (dev),
    .corr_out     (corr_out),
    .offset_rd    (offset_rd),
    .seen         (seen),
    .apply_evt    (apply_evt)
);

// File: tb/sim_afc_gearshift.sv
`timescale 1ns/1ps
module sim_afc_gearshift;
    localparam int ERR_W = 10, CORR_W = 10, DEV_W = 9;
    localparam int MAXV = 511, MINV = -512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic preamble_det = 1'b0;
    logic pkt_end = 1'b0;
    logic multi_pkt = 1'b0;
    logic [7:0] ctrl_byte = 8'h40;
    logic [2:0] wait_pre = 3'd1;
    logic [2:0] wait_post = 3'd0;
    logic [DEV_W-1:0] dev = 9'd511;
    logic signed [CORR_W-1:0] corr_out, offset_rd;

    always #4 clk = ~clk;

    afc_gearshift #(.ERR_W(ERR_W), .CORR_W(CORR_W), .DEV_W(DEV_W)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .err_in(err_in),
        .preamble_det(preamble_det), .pkt_end(pkt_end), .multi_pkt(multi_pkt),
        .ctrl_byte(ctrl_byte), .wait_pre(wait_pre), .wait_post(wait_post),
        .dev(dev), .corr_out(corr_out), .offset_rd(offset_rd)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit started = 0;

    // reference model state
    int m_acc = 0, m_off = 0, m_pos = 0;
    bit m_trk = 0;

    always @(posedge clk) begin
        int code, gear, lim, s;
        bit en, rs;
        en = ctrl_byte[6];
        code = m_trk ? int'(wait_post) : int'(wait_pre);
        gear = m_trk ? int'(ctrl_byte[2:0]) : int'(ctrl_byte[5:3]);
        rs = pkt_end || (preamble_det && !m_trk);
        if (rst) begin
            m_acc = 0; m_off = 0; m_pos = 0; m_trk = 0;
        end else begin
            if (!en) begin
                m_acc = 0; m_pos = 0;
            end else if (pkt_end) begin
                m_pos = 0;
                if (multi_pkt) m_acc = 0;
            end else if (rs || code == 0) begin
                m_pos = 0;
            end else if (bit_tick) begin
                m_pos++;
                if (m_pos == 2) begin
                    s = m_acc + (int'(err_in) >>> gear);
                    if (s > MAXV) s = MAXV;
                    if (s < MINV) s = MINV;
                    lim = ctrl_byte[7] ? int'(dev) : 2 * int'(dev);
                    if ((s < 0 ? -s : s) > lim) s = 0;
                    m_acc = s; m_off = s;
                end
                if (m_pos == 2 + 2 * code) m_pos = 0;
            end
            if (pkt_end) m_trk = 0;
            else if (preamble_det) m_trk = 1;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (started) begin
        check(cur_req, int'(corr_out), m_acc, "corr_out");
        check(cur_req, int'(offset_rd), m_off, "offset_rd");
    end

    // issue n ticks spaced gap clocks apart, error sample from a generator
    task automatic ticks(int n, int gap, int base, int step);
        for (int i = 0; i < n; i++) begin
            err_in = ERR_W'(base + step * (i % 5));
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            for (int k = 1; k < gap; k++) @(negedge clk);
        end
    endtask

    task automatic pulse_pre();
        preamble_det = 1'b1; @(negedge clk); preamble_det = 1'b0;
    endtask
    task automatic pulse_end();
        pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(corr_out), 0, "reset corr");
        check("R1", int'(offset_rd), 0, "reset offset");
        rst = 1'b0;
        started = 1;

        cur_req = "R2 R3";
        ctrl_byte = 8'h40; wait_pre = 3'd1; dev = 9'd511;
        ticks(12, 3, 5, 3);
        wait_pre = 3'd3; ctrl_byte = {2'b01, 3'd2, 3'd0};
        ticks(20, 1, -20, -7);
        // R2: explicit apply position, fresh cycle after enable toggle
        ctrl_byte = 8'h00; @(negedge clk);
        ctrl_byte = 8'h40; wait_pre = 3'd1; err_in = 10'sd8;
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
        check("R2", int'(corr_out), 0, "no step on tick 1");
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
        check("R2", int'(corr_out), 8, "step on tick 2");

        cur_req = "R10";
        dev = 9'd511; ctrl_byte = 8'h40;
        ticks(16, 2, 300, 10);
        check("R10", int'(corr_out), MAXV, "saturated high");
        ticks(24, 2, -400, -20);
        check("R10", int'(corr_out), MINV, "saturated low");

        cur_req = "R6";
        ctrl_byte = 8'h00; @(negedge clk); ctrl_byte = 8'h40;
        dev = 9'd20;
        ticks(24, 2, 15, 0);
        cur_req = "R7";
        ctrl_byte = 8'hC0;
        ticks(24, 2, 7, 2);
        ticks(16, 1, -9, 0);

        cur_req = "R4";
        ctrl_byte = {2'b01, 3'd0, 3'd1}; dev = 9'd400;
        wait_pre = 3'd1; wait_post = 3'd2;
        ticks(5, 2, 30, 0);
        pulse_pre();
        ticks(18, 2, 40, -10);
        pulse_pre();
        ticks(7, 1, 12, 1);

        cur_req = "R5";
        wait_post = 3'd0;
        ticks(15, 1, 100, 5);
        check("R5", int'(corr_out), m_acc, "frozen after detection");

        cur_req = "R8 R11";
        multi_pkt = 1'b0;
        pulse_end();
        ticks(9, 2, 25, 0);
        multi_pkt = 1'b1;
        pulse_end();
        check("R8", int'(corr_out), 0, "multi-packet clear");
        check("R11", int'(offset_rd), m_off, "read-back kept after clear");
        ticks(10, 2, -30, 4);
        pulse_pre(); wait_post = 3'd1;
        ticks(8, 3, 50, 0);
        pulse_end();

        cur_req = "R9";
        ticks(4, 2, 60, 0);
        ctrl_byte[6] = 1'b0;
        ticks(8, 1, 60, 0);
        check("R9", int'(corr_out), 0, "disabled output");
        check("R11", int'(offset_rd), m_off, "read-back kept while disabled");
        ctrl_byte[6] = 1'b1;
        ticks(8, 2, -45, 3);

        cur_req = "R1";
        rst = 1'b1; @(negedge clk); @(negedge clk);
        check("R1", int'(corr_out), 0, "reset corr again");
        check("R1", int'(offset_rd), 0, "reset offset again");
        rst = 1'b0;
        ticks(4, 2, 3, 0);

        started = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule